// File: doc/BRIEF.md
# SIMD Widening Shift-Left Unit

This unit is a vector datapath stage that lengthens narrow integer elements to twice their width and then moves them left by an immediate amount. The source vector is split into 128-bit lanes, and each lane is handled on its own. Only the lower 64 bits of a lane supply elements. Each of those elements is extended with its sign or with zeros, shifted left, and written as a double-width element that fills the whole lane of the result. A further mode turns the lower 64-bit doubleword of each lane into a 128-bit value, either signed or unsigned.

The caller presents a 32-bit instruction word together with the source vector and a vector-length select that chooses one lane or two. The unit decodes the instruction word itself. The result comes back with the destination register index and a flag that marks an instruction word the unit does not recognise.

Both edges of the unit use a valid/ready handshake. In the default build, a single output register separates the input side from the output side. A transfer takes place on a clock edge where valid and ready are both high. The input side is ready when the output register is empty, or when the output register is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output holds its contents without change.

Top module: `simd_widen_shl`

## Requirements
- R1: When `in_insn[31:13]` matches 0x77082000 with bit 18 ignored, the unit works in byte-to-halfword mode. For each lane, result halfword j (j = 0..7) is source byte j of that lane's low half, extended and then shifted left by `in_insn[12:10]`. Bit 18 = 0 selects sign extension and bit 18 = 1 selects zero extension.
- R2: When `in_insn[31:14]` matches 0x77084000 with bit 18 ignored, the unit works in halfword-to-word mode. Result word j (j = 0..3) is source halfword j of the lane's low half, extended as in R1 and shifted left by `in_insn[13:10]`.
- R3: When `in_insn[31:15]` matches 0x77088000 with bit 18 ignored, the unit works in word-to-doubleword mode. Result doubleword j (j = 0..1) is source word j of the lane's low half, extended as in R1 and shifted left by `in_insn[14:10]`.
- R4: In the shift modes, extension to the destination width happens before the shift. Bits moved past the top of the destination element are lost and never reach the neighbouring element.
- R5: When `in_insn[31:10]` matches 0x77090000 with bit 18 ignored, the 128-bit lane result is the lane's lower 64-bit doubleword, sign-extended (bit 18 = 0) or zero-extended (bit 18 = 1) to 128 bits.
- R6: The upper 64 bits of every source lane have no effect on the result.
- R7: With `in_vl256` = 1, both lanes are computed in the same way. With `in_vl256` = 0, only lane 0 (bits 127:0) is computed and result bits 255:128 are zero.
- R8: An instruction word that matches none of the encodings in R1, R2, R3 and R5 sets `out_illegal` and gives an all-zero `out_data`. A recognised word clears `out_illegal`.
- R9: `out_rd` carries `in_insn[4:0]` of the same transfer as the data.
- R10: Each accepted input appears at the output one cycle later. While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` does not change, and `in_ready` is low.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transfer request |
| in_ready | output | 1 | Unit can accept an input |
| in_insn | input | 32 | Instruction word: opcode, immediate, register fields |
| in_data | input | 256 | Source vector |
| in_vl256 | input | 1 | 1 selects two lanes, 0 selects lane 0 only |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Result vector |
| out_rd | output | 5 | Destination register index |
| out_illegal | output | 1 | Instruction word not recognised |

## Verification
A wrong decode or a bad element shift shows up in `out_data` on the cycle right after the input is accepted. That result is compared against an arithmetic model over every immediate value, both extension kinds and both vector lengths. A valid register that loses its state, or a data register that reloads while the output is stalled, is visible at the ports within one cycle as a dropped result or a changed result during back-pressure. A lane-enable or mask fault appears as non-zero upper lanes or non-zero data alongside `out_illegal`.

// File: rtl/swsl_pkg.sv
package swsl_pkg;
  localparam int LANE_W    = 128;
  localparam int NUM_LANES = 2;
  localparam int VEC_W     = LANE_W * NUM_LANES;
  localparam int HALF_W    = LANE_W / 2;
  localparam int INSN_W    = 32;
  localparam int REG_IDX_W = 5;
  localparam int SHAMT_W   = 5;
  localparam int NUM_SIZES = 3;

  typedef enum logic [1:0] {
    WM_B2H = 2'd0,
    WM_H2W = 2'd1,
    WM_W2D = 2'd2,
    WM_D2Q = 2'd3
  } widen_mode_e;

  typedef struct packed {
    logic                 legal;
    widen_mode_e          mode;
    logic                 zext;
    logic [SHAMT_W-1:0]   shamt;
    logic [REG_IDX_W-1:0] rd;
  } widen_op_t;
endpackage

// File: rtl/swsl_decode.sv
module swsl_decode
  import swsl_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output widen_op_t         op
);
  logic unused_rs;
  assign unused_rs = ^insn[9:5];

  always_comb begin
    op       = '0;
    op.mode  = WM_B2H;
    op.rd    = insn[REG_IDX_W-1:0];
    op.zext  = insn[18];
    if (insn[31:20] == 12'h770 && insn[19]) begin
      case (insn[17:15])
        3'b000: begin
          if (insn[14]) begin
            op.legal = 1'b1;
            op.mode  = WM_H2W;
            op.shamt = {1'b0, insn[13:10]};
          end else if (insn[13]) begin
            op.legal = 1'b1;
            op.mode  = WM_B2H;
            op.shamt = {2'b00, insn[12:10]};
          end
        end
        3'b001: begin
          op.legal = 1'b1;
          op.mode  = WM_W2D;
          op.shamt = insn[14:10];
        end
        3'b010: begin
          if (insn[14:10] == 5'd0) begin
            op.legal = 1'b1;
            op.mode  = WM_D2Q;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/swsl_lane.sv
module swsl_lane
  import swsl_pkg::*;
(
  input  logic [HALF_W-1:0]  src,
  input  widen_mode_e        mode,
  input  logic               zext,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [LANE_W-1:0]  res
);
  logic [LANE_W-1:0] sz_res [NUM_SIZES];
  logic [LANE_W-1:0] quad_res;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int SW = 8 << k;
    localparam int DW = 2 * SW;
    localparam int NE = HALF_W / SW;
    logic [LANE_W-1:0] part;
    for (genvar j = 0; j < NE; j++) begin : g_elem
      logic [SW-1:0] narrow;
      logic          fill;
      logic [DW-1:0] wide;
      assign narrow = src[j*SW +: SW];
      assign fill   = ~zext & narrow[SW-1];
      assign wide   = {{SW{fill}}, narrow};
      assign part[j*DW +: DW] = wide << shamt;
    end
    assign sz_res[k] = part;
  end

  assign quad_res = {{HALF_W{~zext & src[HALF_W-1]}}, src};

  always_comb begin
    case (mode)
      WM_B2H:  res = sz_res[0];
      WM_H2W:  res = sz_res[1];
      WM_W2D:  res = sz_res[2];
      default: res = quad_res;
    endcase
  end
endmodule

// File: rtl/simd_widen_shl.sv
module simd_widen_shl
  import swsl_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [INSN_W-1:0]    in_insn,
  input  logic [VEC_W-1:0]     in_data,
  input  logic                 in_vl256,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [VEC_W-1:0]     out_data,
  output logic [REG_IDX_W-1:0] out_rd,
  output logic                 out_illegal
);
  widen_op_t        op;
  logic [VEC_W-1:0] comb_data;

  swsl_decode u_decode (
    .insn (in_insn),
    .op   (op)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_res;
    logic              lane_en;
    logic              unused_hi;
    assign unused_hi = ^in_data[l*LANE_W+HALF_W +: HALF_W];
    assign lane_en   = (l == 0) || in_vl256;

    swsl_lane u_lane (
      .src   (in_data[l*LANE_W +: HALF_W]),
      .mode  (op.mode),
      .zext  (op.zext),
      .shamt (op.shamt),
      .res   (lane_res)
    );

    assign comb_data[l*LANE_W +: LANE_W] = (op.legal && lane_en) ? lane_res : '0;
  end

  if (REGISTERED) begin : g_reg
    logic                 v_q;
    logic [VEC_W-1:0]     data_q;
    logic [REG_IDX_W-1:0] rd_q;
    logic                 ill_q;

    assign in_ready = !v_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        data_q <= '0;
        rd_q   <= '0;
        ill_q  <= 1'b0;
      end else if (in_ready) begin
        v_q <= in_valid;
        if (in_valid) begin
          data_q <= comb_data;
          rd_q   <= op.rd;
          ill_q  <= !op.legal;
        end
      end
    end

    assign out_valid   = v_q;
    assign out_data    = data_q;
    assign out_rd      = rd_q;
    assign out_illegal = ill_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk  = clk ^ rst_n;
    assign in_ready    = out_ready;
    assign out_valid   = in_valid;
    assign out_data    = comb_data;
    assign out_rd      = op.rd;
    assign out_illegal = !op.legal;
  end
endmodule

// File: rtl/swsl_chk.sv
module swsl_chk #(
  parameter bit REGISTERED = 1'b1,
  parameter int VEC_W      = 256,
  parameter int LANE_W     = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_vl256,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_data,
  input logic             out_illegal
);
  // R8: an unrecognised word never carries data
  a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_data == '0));

  if (REGISTERED) begin : g_seq
    // R10: a stalled result is held unchanged
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: an accepted input is presented on the next cycle
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    // R10: a stall blocks the input side
    a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

    // R7: a single-lane request leaves the upper lane at zero
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_vl256) |=> (out_data[VEC_W-1:LANE_W] == '0));
  end
endmodule

bind simd_widen_shl swsl_chk #(
  .REGISTERED (REGISTERED),
  .VEC_W      (VEC_W),
  .LANE_W     (LANE_W)
) u_swsl_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_vl256    (in_vl256),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_illegal (out_illegal)
);

// File: tb/simd_widen_shl_tb.sv
module simd_widen_shl_tb;
  localparam time CYC = 8ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_insn = '0;
  logic [255:0] in_data = '0;
  logic         in_vl256 = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_data;
  logic [4:0]   out_rd;
  logic         out_illegal;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CYC/2) clk = ~clk;

  simd_widen_shl u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_insn (in_insn), .in_data (in_data), .in_vl256 (in_vl256),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_data (out_data), .out_rd (out_rd), .out_illegal (out_illegal)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // kind: 0 byte, 1 halfword, 2 word, 3 quad
  function automatic logic [31:0] mk(input int kind, input bit uns, input int imm,
                                     input logic [4:0] rs, input logic [4:0] rd);
    logic [31:0] w;
    case (kind)
      0: w = 32'h7708_2000 | ((imm & 7) << 10);
      1: w = 32'h7708_4000 | ((imm & 15) << 10);
      2: w = 32'h7708_8000 | ((imm & 31) << 10);
      default: w = 32'h7709_0000;
    endcase
    if (uns) w = w | 32'h0004_0000;
    return w | {22'd0, rs, rd};
  endfunction

  function automatic logic [255:0] ref_calc(input logic [31:0] w, input logic [255:0] s,
                                            input logic vl, output logic ill);
    logic [255:0] r;
    logic [31:0]  wn;
    logic         sgn;
    logic         quad;
    int           sw;
    int           ish;
    r = '0; ill = 1'b0; quad = 1'b0; sw = 8; ish = 0;
    sgn = !w[18];
    wn = w & 32'hFFFB_FFFF;
    if ((wn & 32'hFFFF_E000) == 32'h7708_2000) begin sw = 8;  ish = int'(wn[12:10]); end
    else if ((wn & 32'hFFFF_C000) == 32'h7708_4000) begin sw = 16; ish = int'(wn[13:10]); end
    else if ((wn & 32'hFFFF_8000) == 32'h7708_8000) begin sw = 32; ish = int'(wn[14:10]); end
    else if ((wn & 32'hFFFF_FC00) == 32'h7709_0000) quad = 1'b1;
    else ill = 1'b1;
    if (!ill) begin
      for (int l = 0; l < (vl ? 2 : 1); l++) begin
        logic [63:0] lo;
        logic [63:0] hi;
        lo = s[l*128 +: 64];
        if (quad) begin
          hi = (sgn && lo[63]) ? '1 : '0;
          r = r | ({128'd0, hi, lo} << (l*128));
        end else begin
          for (int j = 0; j < 64/sw; j++) begin
            logic [63:0] e;
            logic [63:0] m;
            logic [63:0] dm;
            int          dw;
            dw = 2 * sw;
            m  = (64'd1 << sw) - 64'd1;
            dm = (dw == 64) ? '1 : ((64'd1 << dw) - 64'd1);
            e  = (lo >> (j*sw)) & m;
            if (sgn && e[sw-1]) e = e | ~m;
            e = (e << ish) & dm;
            r = r | ({192'd0, e} << (l*128 + j*dw));
          end
        end
      end
    end
    return r;
  endfunction

  // one transfer with out_ready high; result sampled one cycle later
  task automatic run_one(input string tag, input logic [31:0] w,
                         input logic [255:0] s, input logic vl);
    logic [255:0] exp;
    logic         eill;
    exp = ref_calc(w, s, vl, eill);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_data = s; in_vl256 = vl;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R10 valid"}, {255'd0, out_valid}, 256'd1);
    chk(tag, out_data, exp);
    chk({tag, " R8 flag"}, {255'd0, out_illegal}, {255'd0, eill});
    chk({tag, " R9 rd"}, {251'd0, out_rd}, {251'd0, w[4:0]});
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] s;
    logic [31:0]  w;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 out_valid", {255'd0, out_valid}, 256'd0);
    chk("R11 in_ready", {255'd0, in_ready}, 256'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: every immediate, both extensions, both vector lengths
    for (int kind = 0; kind < 3; kind++) begin
      for (int imm = 0; imm < (8 << kind); imm++) begin
        for (int u = 0; u < 2; u++) begin
          for (int vl = 0; vl < 2; vl++) begin
            for (int rep = 0; rep < 2; rep++) begin
              s = rnd256();
              if (rep == 1) s = s | {4{64'h8080_8080_8080_8080}};
              w = mk(kind, u[0], imm, 5'($urandom), 5'($urandom));
              run_one(kind == 0 ? "R1 R4 R7" : (kind == 1 ? "R2 R4 R7" : "R3 R4 R7"),
                      w, s, vl[0]);
            end
          end
        end
      end
    end

    // R5: quad extend with positive and negative low doublewords
    for (int u = 0; u < 2; u++) begin
      for (int vl = 0; vl < 2; vl++) begin
        s = rnd256();
        s[63] = 1'b1; s[191] = 1'b0;
        run_one("R5", mk(3, u[0], 0, 5'd3, 5'd17), s, vl[0]);
        s[63] = 1'b0; s[191] = 1'b1;
        run_one("R5", mk(3, u[0], 0, 5'd9, 5'd30), s, vl[0]);
      end
    end

    // R6: changing only the upper half of each lane leaves the result unchanged
    for (int kind = 0; kind < 4; kind++) begin
      logic [255:0] s2;
      s  = rnd256();
      s2 = s ^ {64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'hA5A5_5A5A_0F0F_F0F0, 64'd0};
      run_one("R6 base", mk(kind, 1'b0, 1, 5'd1, 5'd2), s, 1'b1);
      run_one("R6 high-half ignored", mk(kind, 1'b0, 1, 5'd1, 5'd2), s2, 1'b1);
    end

    // R8: unrecognised words
    run_one("R8 b/h gap", 32'h7708_0000, rnd256(), 1'b1);
    run_one("R8 field 011", 32'h7709_8000, rnd256(), 1'b1);
    run_one("R8 quad nonzero imm", 32'h7709_0400, rnd256(), 1'b1);
    run_one("R8 field 100", 32'h770A_0000, rnd256(), 1'b1);
    run_one("R8 bit19 clear", 32'h7700_2000, rnd256(), 1'b1);
    run_one("R8 zero word", 32'h0000_0000, rnd256(), 1'b0);

    // R10: back-pressure holds the first result and blocks the second input
    begin
      logic [255:0] e1;
      logic [255:0] e2;
      logic [255:0] s2;
      logic         ill;
      s  = rnd256();
      s2 = rnd256();
      e1 = ref_calc(mk(1, 1'b0, 5, 5'd0, 5'd4), s, 1'b1, ill);
      e2 = ref_calc(mk(2, 1'b1, 7, 5'd0, 5'd5), s2, 1'b1, ill);
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1; in_insn = mk(1, 1'b0, 5, 5'd0, 5'd4); in_data = s; in_vl256 = 1'b1;
      @(negedge clk);
      in_insn = mk(2, 1'b1, 7, 5'd0, 5'd5); in_data = s2;
      for (int c = 0; c < 3; c++) begin
        chk("R10 stall valid", {255'd0, out_valid}, 256'd1);
        chk("R10 stall in_ready", {255'd0, in_ready}, 256'd0);
        chk("R10 stall data", out_data, e1);
        @(negedge clk);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R10 second after release", out_data, e2);
      chk("R9 second rd", {251'd0, out_rd}, 256'd5);
      @(negedge clk);
      chk("R10 drained", {255'd0, out_valid}, 256'd0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule